// File: doc/BRIEF.md
# Two-Wire Memory Transaction Sequencer

This block runs whole transactions on a two-wire serial bus by issuing a chain of primitive commands (start condition, stop condition, write one byte, read one byte) to a bit-level engine beneath it. It supports three kinds of transaction. A presence probe addresses a target and checks for an acknowledge. A write sends an internal address of zero to four bytes followed by a stream of data bytes. A random read first loads the target's address pointer, then reads a stream of bytes back.

A request is accepted with a valid/ready handshake. Write data arrives on a byte stream and read data leaves on another, each with valid/ready flow control. A separate valid/done handshake drives the bit engine, with one command outstanding at a time. When the final stop condition has completed, the block pulses `done` and reports an abort flag and a count of write-data bytes that were not acknowledged. An optional fold mode merges the internal-address bits above the selected address length into the low bits of the device address, for targets that hide extra address bits there.

Top module: `i2c_txn_seq`

## Requirements
- R1: A probe (`req_kind`=0) issues START, WRITE of {dev,0}, STOP. `err` is 1 exactly when that byte is not acknowledged. Command codes on `bit_cmd_op` are 0=START, 1=STOP, 2=WRITE, 3=READ.
- R2: In a write (`req_kind`=1) or a read with `req_alen`>0, the `req_alen` internal-address bytes follow WRITE {dev,0}, most significant byte first. Byte k is `req_addr[8k+7:8k]`.
- R3: A read (`req_kind`=2) with `req_alen`>0 issues STOP and then START after the last address byte, followed by WRITE {dev,1}.
- R4: A read with `req_alen`=0 issues WRITE {dev,1} directly after the first START, with no address phase.
- R5: Each READ command carries `bit_cmd_nack`=0 except the last one of the transaction, which carries 1. STOP follows it. Read bytes appear on `rd_data` in order and are held while `rd_ready` is low.
- R6: A missing acknowledge on the device-address byte or on any internal-address byte ends the transaction. The block sets `err`=1, issues STOP and issues no further bytes.
- R7: A missing acknowledge on a write-data byte does not stop the transfer. `fail_cnt` reports how many data bytes went unacknowledged.
- R8: With `req_fold`=1, the device address becomes `dev | ((req_addr >> 8*req_alen) & FOLD_MASK)`, with FOLD_MASK defaulting to 7'h07. With `req_fold`=0 the device address is used unchanged.
- R9: `req_ready` is low from acceptance until the final STOP has completed. `done` pulses once, on the cycle after the STOP command's completion.
- R10: After reset, `req_ready`=1 while `err`, `fail_cnt`, `done` and `bit_cmd_valid` are 0. `err` and `fail_cnt` keep their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_kind | input | 2 | 0 probe, 1 write, 2 read |
| req_dev | input | 7 | Device address |
| req_addr | input | ADDR_W (32) | Internal address |
| req_alen | input | ALEN_W (3) | Internal address length in bytes, 0..ADDR_BYTES |
| req_len | input | LEN_W (16) | Number of data bytes |
| req_fold | input | 1 | Fold upper address bits into the device address |
| wr_valid | input | 1 | Write data byte offered |
| wr_ready | output | 1 | Write data byte taken |
| wr_data | input | 8 | Write data byte |
| rd_valid | output | 1 | Read data byte offered |
| rd_ready | input | 1 | Read data byte taken |
| rd_data | output | 8 | Read data byte |
| bit_cmd_valid | output | 1 | Command to bit engine, held until done |
| bit_cmd_op | output | 2 | Command code |
| bit_cmd_data | output | 8 | Byte to send |
| bit_cmd_nack | output | 1 | Level to return after a READ (1 = no acknowledge) |
| bit_done | input | 1 | Command completed (one cycle) |
| bit_nack | input | 1 | WRITE was not acknowledged |
| bit_rdata | input | 8 | Byte received by READ |
| done | output | 1 | Transaction completed pulse |
| err | output | 1 | Transaction aborted or probe found no target |
| fail_cnt | output | FAIL_W (16) | Unacknowledged write-data bytes |

## Verification
The hardest case to reach is an abort that lands partway through a multi-byte address phase. The design must then skip both the intermediate stop/restart and the whole data phase, yet still finish with exactly one STOP. The bench model of the bit engine withholds the acknowledge on chosen WRITE commands, using a per-transaction mask indexed by the position of each WRITE. This places a missing acknowledge on the second address byte, on the read-direction device byte, or on chosen data bytes. The bench then compares the full logged command sequence against one it builds from the requirements.

// File: rtl/i2c_txn_pkg.sv
// Shared encodings for the two-wire transaction sequencer.
// Assumes the bit engine understands the four command codes below.
package i2c_txn_pkg;

    typedef enum logic [1:0] {
        BOP_START = 2'd0,
        BOP_STOP  = 2'd1,
        BOP_WRITE = 2'd2,
        BOP_READ  = 2'd3
    } bop_t;

    typedef enum logic [1:0] {
        TXN_PROBE = 2'd0,
        TXN_WRITE = 2'd1,
        TXN_READ  = 2'd2
    } txn_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_DEVW,
        ST_ADDR,
        ST_MSTOP,
        ST_RSTART,
        ST_DEVR,
        ST_RDATA,
        ST_RPUSH,
        ST_WFETCH,
        ST_WDATA,
        ST_STOP
    } seq_st_t;

endpackage

// File: rtl/i2c_txn_addr.sv
// Address shaping: picks one internal-address byte by index and forms the
// effective device address, folding upper address bits when asked.
// Assumes alen never exceeds ADDR_BYTES.
module i2c_txn_addr #(
    parameter int         ADDR_BYTES = 4,
    parameter logic [6:0] FOLD_MASK  = 7'h07,
    localparam int        ADDR_W     = 8 * ADDR_BYTES,
    localparam int        ALEN_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic [6:0]        dev,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ALEN_W-1:0] alen,
    input  logic              fold,
    input  logic [ALEN_W-1:0] idx,
    output logic [6:0]        dev_eff,
    output logic [7:0]        addr_byte
);

    logic [7:0]        bytes [ADDR_BYTES];
    logic [ADDR_W-1:0] upper;

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
        assign bytes[g] = addr[8*g +: 8];
    end

    // Bits left above the used address length
    assign upper   = addr >> {alen, 3'b000};
    assign dev_eff = fold ? (dev | (upper[6:0] & FOLD_MASK)) : dev;

    // Select the address byte the controller is sending
    always_comb begin
        addr_byte = 8'h00;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (idx == ALEN_W'(i)) addr_byte = bytes[i];
        end
    end

endmodule

// File: rtl/i2c_txn_tally.sv
// Saturating failure counter, cleared when a transaction starts.
// Assumes clr and inc are never both wanted as an increment.
module i2c_txn_tally #(
    parameter int FAIL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [FAIL_W-1:0] cnt
);

    // Count unacknowledged data bytes, stopping at full scale
    always_ff @(posedge clk) begin
        if (!rst_n || clr)   cnt <= '0;
        else if (inc && cnt != '1) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/i2c_txn_ctrl.sv
// Transaction controller: walks probe, write and random-read sequences,
// issuing one bit-engine command at a time and holding it until done.
// Assumes bit_done is a single-cycle pulse answering the held command.
module i2c_txn_ctrl
    import i2c_txn_pkg::*;
#(
    parameter int  ADDR_BYTES = 4,
    parameter int  LEN_W      = 16,
    localparam int ADDR_W     = 8 * ADDR_BYTES,
    localparam int ALEN_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [6:0]        req_dev,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ALEN_W-1:0] req_alen,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_fold,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              bit_cmd_valid,
    output logic [1:0]        bit_cmd_op,
    output logic [7:0]        bit_cmd_data,
    output logic              bit_cmd_nack,
    input  logic              bit_done,
    input  logic              bit_nack,
    input  logic [7:0]        bit_rdata,
    output logic [6:0]        dev_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ALEN_W-1:0] alen_q,
    output logic              fold_q,
    output logic [ALEN_W-1:0] idx_q,
    input  logic [6:0]        dev_eff,
    input  logic [7:0]        addr_byte,
    output logic              accept,
    output logic              fail_inc,
    output logic              done,
    output logic              err
);

    seq_st_t          st;
    txn_t             kind_q;
    logic [LEN_W-1:0] rem_q;
    logic [7:0]       byte_q;
    logic             last;
    logic             step;

    assign accept   = (st == ST_IDLE) && req_valid;
    assign last     = (rem_q == LEN_W'(1));
    assign step     = bit_cmd_valid && bit_done;
    assign fail_inc = (st == ST_WDATA) && bit_done && bit_nack;

    // Handshake outputs derived from the state
    assign req_ready = (st == ST_IDLE);
    assign wr_ready  = (st == ST_WFETCH);
    assign rd_valid  = (st == ST_RPUSH);
    assign rd_data   = byte_q;

    // Command presented to the bit engine
    always_comb begin
        bit_cmd_valid = 1'b1;
        bit_cmd_op    = BOP_WRITE;
        bit_cmd_data  = 8'h00;
        bit_cmd_nack  = 1'b0;
        unique case (st)
            ST_START, ST_RSTART: bit_cmd_op = BOP_START;
            ST_MSTOP, ST_STOP:   bit_cmd_op = BOP_STOP;
            ST_DEVW:             bit_cmd_data = {dev_eff, 1'b0};
            ST_DEVR:             bit_cmd_data = {dev_eff, 1'b1};
            ST_ADDR:             bit_cmd_data = addr_byte;
            ST_WDATA:            bit_cmd_data = byte_q;
            ST_RDATA: begin
                bit_cmd_op   = BOP_READ;
                bit_cmd_nack = last;
            end
            default:             bit_cmd_valid = 1'b0;
        endcase
    end

    // Sequence state, request capture and result flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            kind_q <= TXN_PROBE;
            dev_q  <= '0;
            addr_q <= '0;
            alen_q <= '0;
            fold_q <= 1'b0;
            idx_q  <= '0;
            rem_q  <= '0;
            byte_q <= '0;
            err    <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    kind_q <= (req_kind == 2'd3) ? TXN_PROBE : txn_t'(req_kind);
                    dev_q  <= req_dev;
                    addr_q <= req_addr;
                    alen_q <= req_alen;
                    fold_q <= req_fold;
                    rem_q  <= req_len;
                    err    <= 1'b0;
                    st     <= ST_START;
                end
                ST_START: if (step) begin
                    st <= (kind_q == TXN_READ && alen_q == '0) ? ST_DEVR : ST_DEVW;
                end
                ST_DEVW: if (step) begin
                    idx_q <= alen_q - ALEN_W'(1);
                    if (bit_nack) begin
                        err <= 1'b1;
                        st  <= ST_STOP;
                    end else if (kind_q == TXN_PROBE) st <= ST_STOP;
                    else if (alen_q != '0)            st <= ST_ADDR;
                    else if (rem_q == '0)             st <= ST_STOP;
                    else                              st <= ST_WFETCH;
                end
                ST_ADDR: if (step) begin
                    if (bit_nack) begin
                        err <= 1'b1;
                        st  <= ST_STOP;
                    end else if (idx_q != '0) idx_q <= idx_q - ALEN_W'(1);
                    else if (kind_q == TXN_READ) st <= ST_MSTOP;
                    else if (rem_q == '0)        st <= ST_STOP;
                    else                         st <= ST_WFETCH;
                end
                ST_MSTOP:  if (step) st <= ST_RSTART;
                ST_RSTART: if (step) st <= ST_DEVR;
                ST_DEVR: if (step) begin
                    if (bit_nack) begin
                        err <= 1'b1;
                        st  <= ST_STOP;
                    end else st <= (rem_q == '0) ? ST_STOP : ST_RDATA;
                end
                ST_RDATA: if (step) begin
                    byte_q <= bit_rdata;
                    st     <= ST_RPUSH;
                end
                ST_RPUSH: if (rd_ready) begin
                    rem_q <= rem_q - 1'b1;
                    st    <= last ? ST_STOP : ST_RDATA;
                end
                ST_WFETCH: if (wr_valid) begin
                    byte_q <= wr_data;
                    st     <= ST_WDATA;
                end
                ST_WDATA: if (step) begin
                    rem_q <= rem_q - 1'b1;
                    st    <= last ? ST_STOP : ST_WFETCH;
                end
                ST_STOP: if (step) begin
                    done <= 1'b1;
                    st   <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/i2c_txn_seq.sv
// Top of the two-wire transaction sequencer: joins the controller, the
// address shaper and the failure counter. Assumes one bit engine below.
module i2c_txn_seq #(
    parameter int         ADDR_BYTES = 4,
    parameter int         LEN_W      = 16,
    parameter int         FAIL_W     = 16,
    parameter logic [6:0] FOLD_MASK  = 7'h07,
    localparam int        ADDR_W     = 8 * ADDR_BYTES,
    localparam int        ALEN_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [6:0]        req_dev,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ALEN_W-1:0] req_alen,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_fold,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              bit_cmd_valid,
    output logic [1:0]        bit_cmd_op,
    output logic [7:0]        bit_cmd_data,
    output logic              bit_cmd_nack,
    input  logic              bit_done,
    input  logic              bit_nack,
    input  logic [7:0]        bit_rdata,
    output logic              done,
    output logic              err,
    output logic [FAIL_W-1:0] fail_cnt
);

    logic [6:0]        dev_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ALEN_W-1:0] alen_q;
    logic              fold_q;
    logic [ALEN_W-1:0] idx_q;
    logic [6:0]        dev_eff;
    logic [7:0]        addr_byte;
    logic              accept;
    logic              fail_inc;

    i2c_txn_ctrl #(
        .ADDR_BYTES(ADDR_BYTES),
        .LEN_W     (LEN_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_kind     (req_kind),
        .req_dev      (req_dev),
        .req_addr     (req_addr),
        .req_alen     (req_alen),
        .req_len      (req_len),
        .req_fold     (req_fold),
        .wr_valid     (wr_valid),
        .wr_ready     (wr_ready),
        .wr_data      (wr_data),
        .rd_valid     (rd_valid),
        .rd_ready     (rd_ready),
        .rd_data      (rd_data),
        .bit_cmd_valid(bit_cmd_valid),
        .bit_cmd_op   (bit_cmd_op),
        .bit_cmd_data (bit_cmd_data),
        .bit_cmd_nack (bit_cmd_nack),
        .bit_done     (bit_done),
        .bit_nack     (bit_nack),
        .bit_rdata    (bit_rdata),
        .dev_q        (dev_q),
        .addr_q       (addr_q),
        .alen_q       (alen_q),
        .fold_q       (fold_q),
        .idx_q        (idx_q),
        .dev_eff      (dev_eff),
        .addr_byte    (addr_byte),
        .accept       (accept),
        .fail_inc     (fail_inc),
        .done         (done),
        .err          (err)
    );

    i2c_txn_addr #(
        .ADDR_BYTES(ADDR_BYTES),
        .FOLD_MASK (FOLD_MASK)
    ) u_addr (
        .dev      (dev_q),
        .addr     (addr_q),
        .alen     (alen_q),
        .fold     (fold_q),
        .idx      (idx_q),
        .dev_eff  (dev_eff),
        .addr_byte(addr_byte)
    );

    i2c_txn_tally #(
        .FAIL_W(FAIL_W)
    ) u_tally (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (accept),
        .inc  (fail_inc),
        .cnt  (fail_cnt)
    );

endmodule

// File: rtl/i2c_txn_chk.sv
// Port-level protocol checks for the transaction sequencer, bound to the top.
// Assumes the command codes of i2c_txn_pkg.
module i2c_txn_chk #(
    parameter int FAIL_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              bit_cmd_valid,
    input logic [1:0]        bit_cmd_op,
    input logic [7:0]        bit_cmd_data,
    input logic              bit_done,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [7:0]        rd_data,
    input logic              wr_ready,
    input logic              done,
    input logic              err,
    input logic [FAIL_W-1:0] fail_cnt
);

    // R9: a command stays put until the engine finishes it
    p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cmd_valid && !bit_done) |=> (bit_cmd_valid && $stable(bit_cmd_op) && $stable(bit_cmd_data)));

    // R9: completion only follows a finished STOP
    p_done_after_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bit_cmd_valid && bit_cmd_op == 2'd1 && bit_done));

    // R9: no new request is taken while a command is out
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cmd_valid |-> !req_ready);

    // R5: a read byte waits unchanged for the consumer
    p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R5: streams and engine are never served together
    p_one_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, wr_ready, bit_cmd_valid}));

    // R10: results hold while idle with no request
    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> ($stable(err) && $stable(fail_cnt)));

    // R7: the failure count only steps by one or clears
    p_fail_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_cnt != $past(fail_cnt)) |-> (fail_cnt == FAIL_W'($past(fail_cnt) + 1'b1) || fail_cnt == '0));

endmodule

bind i2c_txn_seq i2c_txn_chk #(.FAIL_W(FAIL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .bit_cmd_valid(bit_cmd_valid),
    .bit_cmd_op   (bit_cmd_op),
    .bit_cmd_data (bit_cmd_data),
    .bit_done     (bit_done),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .rd_data      (rd_data),
    .wr_ready     (wr_ready),
    .done         (done),
    .err          (err),
    .fail_cnt     (fail_cnt)
);

// File: tb/sim_i2c_txn_seq.sv
// Bench: a vector table of transactions checked against command traces
// built from the requirements, then directed reset and hold checks.
module sim_i2c_txn_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [6:0]  req_dev = 7'd0;
    logic [31:0] req_addr = 32'd0;
    logic [2:0]  req_alen = 3'd0;
    logic [15:0] req_len = 16'd0;
    logic        req_fold = 1'b0;
    logic        wr_valid;
    logic        wr_ready;
    logic [7:0]  wr_data;
    logic        rd_valid;
    logic        rd_ready;
    logic [7:0]  rd_data;
    logic        bit_cmd_valid;
    logic [1:0]  bit_cmd_op;
    logic [7:0]  bit_cmd_data;
    logic        bit_cmd_nack;
    logic        bit_done = 1'b0;
    logic        bit_nack = 1'b0;
    logic [7:0]  bit_rdata = 8'h00;
    logic        done;
    logic        err;
    logic [15:0] fail_cnt;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    i2c_txn_seq u0 (.*);

    // Bench-side bit engine and stream endpoints
    logic        log_clr = 1'b0;
    logic [7:0]  nmask = 8'h00;
    logic        eng_busy = 1'b0;
    logic [1:0]  eng_cnt = 2'd0;
    logic [10:0] trace [64];
    int          tn = 0, wi = 0, ri = 0, rn = 0, wn = 0;
    logic [7:0]  rdbuf [16];
    logic        bp = 1'b0;

    assign wr_valid = 1'b1;
    assign wr_data  = 8'h50 + 8'(wn);
    assign rd_ready = bp;

    always @(posedge clk) begin
        bit_done <= 1'b0;
        bp       <= ~bp;
        if (log_clr) begin
            tn <= 0; wi <= 0; ri <= 0; rn <= 0; wn <= 0;
            eng_busy <= 1'b0;
        end else begin
            if (!eng_busy && !bit_done && bit_cmd_valid) begin
                eng_busy <= 1'b1;
                eng_cnt  <= 2'd2;
                if (tn < 64) trace[tn] <= {bit_cmd_op, bit_cmd_nack, bit_cmd_data};
                tn <= tn + 1;
                bit_nack <= 1'b0;
                if (bit_cmd_op == 2'd2) begin
                    bit_nack <= (wi < 8) ? nmask[wi] : 1'b0;
                    wi <= wi + 1;
                end
                if (bit_cmd_op == 2'd3) begin
                    bit_rdata <= 8'hA0 + 8'(ri);
                    ri <= ri + 1;
                end
            end else if (eng_busy) begin
                if (eng_cnt == 2'd0) begin
                    bit_done <= 1'b1;
                    eng_busy <= 1'b0;
                end else eng_cnt <= eng_cnt - 2'd1;
            end
            if (rd_valid && rd_ready) begin
                if (rn < 16) rdbuf[rn] <= rd_data;
                rn <= rn + 1;
            end
            if (wr_valid && wr_ready) wn <= wn + 1;
        end
    end

    // Vector layout: kind[56:55] dev[54:48] addr[47:16] alen[15:13] len[12:9] fold[8] mask[7:0]
    localparam int NV = 11;
    localparam logic [56:0] VEC [NV] = '{
        {2'd0, 7'h50, 32'h0000_0000, 3'd0, 4'd0, 1'b0, 8'h00}, // R1 probe present
        {2'd0, 7'h51, 32'h0000_0000, 3'd0, 4'd0, 1'b0, 8'h01}, // R1 probe absent
        {2'd1, 7'h50, 32'h0000_1234, 3'd2, 4'd3, 1'b0, 8'h00}, // R2 write
        {2'd1, 7'h22, 32'hA1B2_C3D4, 3'd4, 4'd4, 1'b0, 8'hA0}, // R2 R7 data nacks
        {2'd2, 7'h50, 32'h0000_0010, 3'd1, 4'd3, 1'b0, 8'h00}, // R3 R5 read
        {2'd2, 7'h3C, 32'h0000_0000, 3'd0, 4'd2, 1'b0, 8'h00}, // R4 read, no address
        {2'd2, 7'h50, 32'h0000_4455, 3'd2, 4'd2, 1'b0, 8'h04}, // R6 address nack
        {2'd1, 7'h50, 32'h0000_0305, 3'd1, 4'd1, 1'b1, 8'h00}, // R8 fold write
        {2'd2, 7'h50, 32'h0000_0277, 3'd1, 4'd1, 1'b1, 8'h00}, // R8 fold read
        {2'd1, 7'h11, 32'h0000_0000, 3'd0, 4'd2, 1'b0, 8'h00}, // R2 write, no address
        {2'd2, 7'h3C, 32'h0000_0000, 3'd0, 4'd2, 1'b0, 8'h01}  // R6 read-address nack
    };

    logic [10:0] exp_tr [64];
    int          en;
    logic        exp_err;
    int          exp_fail;

    task automatic push(input logic [1:0] op, input logic nk, input logic [7:0] d);
        exp_tr[en] = {op, nk, d};
        en++;
    endtask

    // Expected command sequence from the requirements
    task automatic build(input logic [56:0] v);
        logic [1:0]  k  = v[56:55];
        logic [6:0]  dv = v[54:48];
        logic [31:0] ad = v[47:16];
        int          al = int'(v[15:13]);
        int          ln = int'(v[12:9]);
        logic [7:0]  mk = v[7:0];
        int          w  = 0;
        logic [63:0] up;
        en = 0; exp_err = 1'b0; exp_fail = 0;
        up = {32'd0, ad} >> (8 * al);
        if (v[8]) dv = dv | (up[6:0] & 7'h07);
        push(2'd0, 1'b0, 8'h00);
        if (!(k == 2'd2 && al == 0)) begin
            push(2'd2, 1'b0, {dv, 1'b0});
            if (mk[w]) begin exp_err = 1'b1; push(2'd1, 1'b0, 8'h00); return; end
            w++;
            if (k == 2'd0) begin push(2'd1, 1'b0, 8'h00); return; end
            for (int i = al - 1; i >= 0; i--) begin
                push(2'd2, 1'b0, ad[8*i +: 8]);
                if (mk[w]) begin exp_err = 1'b1; push(2'd1, 1'b0, 8'h00); return; end
                w++;
            end
            if (k == 2'd1) begin
                for (int j = 0; j < ln; j++) begin
                    push(2'd2, 1'b0, 8'h50 + 8'(j));
                    if (w < 8 && mk[w]) exp_fail++;
                    w++;
                end
                push(2'd1, 1'b0, 8'h00);
                return;
            end
            push(2'd1, 1'b0, 8'h00);
            push(2'd0, 1'b0, 8'h00);
        end
        push(2'd2, 1'b0, {dv, 1'b1});
        if (mk[w]) begin exp_err = 1'b1; push(2'd1, 1'b0, 8'h00); return; end
        for (int j = 0; j < ln; j++) push(2'd3, (j == ln - 1), 8'h00);
        push(2'd1, 1'b0, 8'h00);
    endtask

    task automatic check(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, expv);
        end
    endtask

    // Issue one transaction and wait for its completion pulse
    task automatic run(input logic [56:0] v, output bit timed_out);
        int n = 0;
        timed_out = 1'b0;
        @(negedge clk); log_clr = 1'b1; nmask = v[7:0];
        @(negedge clk); log_clr = 1'b0;
        req_kind = v[56:55]; req_dev = v[54:48]; req_addr = v[47:16];
        req_alen = v[15:13]; req_len = {12'd0, v[12:9]}; req_fold = v[8];
        req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        check(req_ready == 1'b0, "R9 busy after accept", int'(req_ready), 0);
        while (!done) begin
            @(negedge clk);
            n++;
            if (n > 2000) begin timed_out = 1'b1; break; end
        end
    endtask

    initial begin
        bit to;
        logic        hold_err;
        logic [15:0] hold_fail;
        repeat (3) @(negedge clk);
        // R10 reset values
        check(req_ready == 1'b1, "R10 reset req_ready", int'(req_ready), 1);
        check(err == 1'b0 && fail_cnt == 16'd0, "R10 reset results", int'(fail_cnt), 0);
        check(bit_cmd_valid == 1'b0 && done == 1'b0, "R10 reset idle", int'(bit_cmd_valid), 0);
        rst_n = 1'b1;

        for (int t = 0; t < NV; t++) begin
            build(VEC[t]);
            run(VEC[t], to);
            if (to) begin
                check(1'b0, $sformatf("R9 watchdog vector %0d", t), 0, 1);
                break;
            end
            // R1 R2 R3 R4 R5 R6 R8 command sequence
            begin
                bit same = (tn == en);
                for (int i = 0; i < en && i < 64; i++) if (trace[i] !== exp_tr[i]) same = 1'b0;
                check(same, $sformatf("R1/R2/R3/R4/R5/R6/R8 trace vector %0d", t), tn, en);
            end
            check(err == exp_err, $sformatf("R1/R6 err vector %0d", t), int'(err), int'(exp_err));
            check(int'(fail_cnt) == exp_fail, $sformatf("R7 fail_cnt vector %0d", t), int'(fail_cnt), exp_fail);
            if (VEC[t][56:55] == 2'd2 && !exp_err) begin
                bit okd = (rn == int'(VEC[t][12:9]));
                for (int j = 0; j < rn && j < 16; j++) if (rdbuf[j] !== 8'hA0 + 8'(j)) okd = 1'b0;
                check(okd, $sformatf("R5 read data vector %0d", t), rn, int'(VEC[t][12:9]));
            end
            if (t == 3) begin
                // R10 results hold while idle
                hold_err = err; hold_fail = fail_cnt;
                repeat (20) @(negedge clk);
                check(err == hold_err && fail_cnt == hold_fail, "R10 results held", int'(fail_cnt), int'(hold_fail));
                check(req_ready == 1'b1, "R9 idle after STOP", int'(req_ready), 1);
            end
        end

        // R10 reset mid-transaction returns to idle
        @(negedge clk); req_kind = 2'd2; req_alen = 3'd1; req_len = 16'd4; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        repeat (5) @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(req_ready == 1'b1 && bit_cmd_valid == 1'b0, "R10 reset mid-transaction", int'(req_ready), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9 watchdog expired: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule